// File: doc/BRIEF.md
# Burst-of-two dual-port synchronous SRAM core

This block is an on-chip memory with one read port and one write port, each with its own data bus. Both ports can accept a command on the same K cycle. Every command moves a pair of words. The first word goes to the address given with the command. The second word goes to that address plus one, and the sum wraps at the top of the address space. The whole block runs from one clock, `clk`, whose period is one data beat. An internal beat phase alternates between the K-rise beat and the K-fall beat, and the output `kphase` shows which beat comes next. Selects, addresses, the first write word and its byte enables are sampled only at K-rise edges. The second write word and its enables are taken at the K-fall edge that follows.

Read words come out in the order of the burst, one word per beat. Read latency is fixed, and the output timing mode decides it. The mode is taken from `oclk_held` while reset is asserted:
- With `oclk_held` high, the block uses single-clock timing: outputs follow the K beats.
- With `oclk_held` low, the block uses separate output clocks, which adds one beat of delay.

`q_oe` shows when the read bus carries data. It drops one beat after the last word of a burst unless another read follows directly. While it is low, `q` is driven to zero. Once started, a burst always runs to the end, whatever the selects do afterwards. The memory contents survive reset.

Top module: `b2sram_core`

## Requirements
- R1: Each accepted command moves exactly two words: word 0 at the sampled address A and word 1 at (A+1) modulo 2^AW, so address 255 is followed by address 0 with the default width.
- R2: The selects `rd_n` and `wr_n` are active low and are sampled only on edges where `kphase` is 1. `kphase` toggles on every clock edge after reset. Select or address values present before an edge with `kphase` 0 are ignored.
- R3: A read and a write can be accepted on the same K-rise edge. If their addresses overlap, the read returns the contents held before that write.
- R4: In single-clock timing (`oclk_held` high during reset), word 0 of a read accepted at edge n is on `q` after edge n+2, and word 1 is on `q` after edge n+3.
- R5: In split output-clock timing (`oclk_held` low during reset), each read word appears one edge later than in R4.
- R6: `q_oe` is 1 exactly on the beats that carry read words. Otherwise `q_oe` is 0 and `q` is all zeros, so the bus is released one beat after a read no-operation.
- R7: Reads accepted on consecutive K-rise edges give an unbroken stream of words with `q_oe` held high.
- R8: `bwe_n` has one active-low bit per 9-bit lane, with bit i controlling data bits 9i+8..9i. It is sampled together with each write word. A lane whose bit is 1 keeps its stored value.
- R9: A read burst that has started delivers both words even if `rd_n` is high on the next K-rise edge. The read bus then goes idle.
- R10: While `rst` is high, `kphase` is 1, `q_oe` is 0 and `q` is 0. The stored data is kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; two edges make one K cycle |
| rst | input | 1 | Synchronous active-high reset |
| oclk_held | input | 1 | Sampled during reset: 1 selects single-clock output timing, 0 selects split output clocks |
| rd_n | input | 1 | Active-low read select |
| rd_addr | input | AW | Read burst base address |
| wr_n | input | 1 | Active-low write select |
| wr_addr | input | AW | Write burst base address |
| wdata | input | DW | Write data, one word per beat |
| bwe_n | input | LANES | Active-low byte-lane write enables, one per beat |
| kphase | output | 1 | 1 when the next edge is a K-rise edge |
| q | output | DW | Read data, zero when idle |
| q_oe | output | 1 | Read bus drive enable |

## Verification
The hardest case to reach is a collision on the same edge: a write and a read to overlapping addresses accepted together. Here the array receives the new word on the same edge that it reads the old one, and this happens for both words of the burst. The stimulus issues the same base address on both ports at a K-rise edge, then reads the address again. A reference model is updated only after it has been read for that cycle. The bench also drives both selects low with unrelated addresses on every K-fall beat, which checks that those beats are ignored. It repeats the key cases after a second reset into split output timing.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;
  // Output timing mode latched during reset
  typedef enum logic {
    OMODE_SPLIT  = 1'b0,
    OMODE_SINGLE = 1'b1
  } omode_e;

  localparam int unsigned BURST_WORDS = 2;
endpackage

// File: rtl/b2sram_beat.sv
module b2sram_beat
  import b2sram_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   oclk_held,
  output logic   kbeat,
  output omode_e omode
);
  // kbeat = 1: the coming edge is a K-rise edge
  always_ff @(posedge clk) begin
    if (rst) begin
      kbeat <= 1'b1;
      omode <= oclk_held ? OMODE_SINGLE : OMODE_SPLIT;
    end else begin
      kbeat <= ~kbeat;
    end
  end
endmodule

// File: rtl/b2sram_wstage.sv
module b2sram_wstage #(
  parameter int AW    = 8,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kbeat,
  input  logic             wr_n,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] bwe_n,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [DW-1:0]    wd,
  output logic [LANES-1:0] wbe
);
  // Word 0 is staged at K-rise, word 1 at K-fall; the array writes each one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      we <= 1'b0;
    end else if (kbeat && !wr_n) begin
      we    <= 1'b1;
      waddr <= wr_addr;
      wd    <= wdata;
      wbe   <= ~bwe_n;
    end else if (!kbeat && we) begin
      waddr <= waddr + 1'b1;
      wd    <= wdata;
      wbe   <= ~bwe_n;
    end else begin
      we <= 1'b0;
    end
  end
endmodule

// File: rtl/b2sram_rstage.sv
module b2sram_rstage #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kbeat,
  input  logic          rd_n,
  input  logic [AW-1:0] rd_addr,
  output logic          re,
  output logic [AW-1:0] raddr
);
  // Burst counter: base, then base+1, regardless of later select level
  always_ff @(posedge clk) begin
    if (rst) begin
      re <= 1'b0;
    end else if (kbeat && !rd_n) begin
      re    <= 1'b1;
      raddr <= rd_addr;
    end else if (!kbeat && re) begin
      raddr <= raddr + 1'b1;
    end else begin
      re <= 1'b0;
    end
  end
endmodule

// File: rtl/b2sram_array.sv
module b2sram_array #(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 2,
  localparam int DW    = LW * LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wd,
  input  logic [LANES-1:0] wbe,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdat,
  output logic             rdv
);
  // One read-first simple dual-port array per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rq;

    always_ff @(posedge clk) begin
      if (we && wbe[g]) begin
        mem[waddr] <= wd[g*LW +: LW];
      end
      if (re) begin
        rq <= mem[raddr];
      end
    end

    assign rdat[g*LW +: LW] = rq;
  end

  always_ff @(posedge clk) begin
    if (rst) rdv <= 1'b0;
    else     rdv <= re;
  end
endmodule

// File: rtl/b2sram_oreg.sv
module b2sram_oreg
  import b2sram_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  omode_e        omode,
  input  logic [DW-1:0] rdat,
  input  logic          rdv,
  output logic [DW-1:0] q,
  output logic          q_oe
);
  logic [DW-1:0] dly_d;
  logic          dly_v;
  logic [DW-1:0] sel_d;
  logic          sel_v;

  // Extra beat of delay when data is launched from the separate output clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_v <= 1'b0;
      dly_d <= '0;
    end else begin
      dly_v <= rdv;
      dly_d <= rdat;
    end
  end

  always_comb begin
    sel_v = (omode == OMODE_SINGLE) ? rdv  : dly_v;
    sel_d = (omode == OMODE_SINGLE) ? rdat : dly_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_oe <= 1'b0;
      q    <= '0;
    end else begin
      q_oe <= sel_v;
      q    <= sel_v ? sel_d : '0;
    end
  end
endmodule

// File: rtl/b2sram_core.sv
module b2sram_core
  import b2sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 2,
  localparam int DW   = LW * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oclk_held,
  input  logic             rd_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_n,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] bwe_n,
  output logic             kphase,
  output logic [DW-1:0]    q,
  output logic             q_oe
);
  omode_e             omode;
  logic               sgl_mode;
  logic               we;
  logic [AW-1:0]      waddr;
  logic [DW-1:0]      wd;
  logic [LANES-1:0]   wbe;
  logic               re;
  logic [AW-1:0]      raddr;
  logic [DW-1:0]      rdat;
  logic               rdv;

  b2sram_beat u_beat (
    .clk       (clk),
    .rst       (rst),
    .oclk_held (oclk_held),
    .kbeat     (kphase),
    .omode     (omode)
  );

  assign sgl_mode = (omode == OMODE_SINGLE);

  b2sram_wstage #(.AW(AW), .DW(DW), .LANES(LANES)) u_wstage (
    .clk     (clk),
    .rst     (rst),
    .kbeat   (kphase),
    .wr_n    (wr_n),
    .wr_addr (wr_addr),
    .wdata   (wdata),
    .bwe_n   (bwe_n),
    .we      (we),
    .waddr   (waddr),
    .wd      (wd),
    .wbe     (wbe)
  );

  b2sram_rstage #(.AW(AW)) u_rstage (
    .clk     (clk),
    .rst     (rst),
    .kbeat   (kphase),
    .rd_n    (rd_n),
    .rd_addr (rd_addr),
    .re      (re),
    .raddr   (raddr)
  );

  b2sram_array #(.AW(AW), .LW(LW), .LANES(LANES)) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (waddr),
    .wd    (wd),
    .wbe   (wbe),
    .re    (re),
    .raddr (raddr),
    .rdat  (rdat),
    .rdv   (rdv)
  );

  b2sram_oreg #(.DW(DW)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .omode (omode),
    .rdat  (rdat),
    .rdv   (rdv),
    .q     (q),
    .q_oe  (q_oe)
  );
endmodule

// File: rtl/b2sram_chk.sv
module b2sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          kphase,
  input logic          rd_n,
  input logic          q_oe,
  input logic [DW-1:0] q,
  input logic          single
);
  // R2: beat phase alternates every edge once out of reset
  a_r2_phase_alt: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (kphase != $past(kphase)));

  // R6: idle read bus carries zeros
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !q_oe |-> (q == '0));

  // R6: every data window spans at least both burst words
  a_r6_two_beats: assert property (@(posedge clk) disable iff (rst)
    $rose(q_oe) |=> q_oe);

  // R4: single-clock timing places word 0 two edges after acceptance
  a_r4_single_lat: assert property (@(posedge clk) disable iff (rst)
    (kphase && !rd_n && single) |=> ##2 q_oe);

  // R5: split timing places word 0 one edge later
  a_r5_split_lat: assert property (@(posedge clk) disable iff (rst)
    (kphase && !rd_n && !single) |=> ##3 q_oe);

  // R9: word 1 follows word 0 even without a further select
  a_r9_burst_done: assert property (@(posedge clk) disable iff (rst)
    (kphase && !rd_n && single) |=> ##3 q_oe);
endmodule

bind b2sram_core b2sram_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .kphase (kphase),
  .rd_n   (rd_n),
  .q_oe   (q_oe),
  .q      (q),
  .single (sgl_mode)
);

// File: tb/sim_b2sram_core.sv
module sim_b2sram_core;
  localparam int AW = 8, LW = 9, LANES = 2, DW = LW * LANES;
  localparam int DEPTH = 1 << AW;
  localparam int NB = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, oclk_held, rd_n, wr_n;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic [DW-1:0]    wdata;
  logic [LANES-1:0] bwe_n;
  wire              kphase;
  wire  [DW-1:0]    q;
  wire              q_oe;

  b2sram_core #(.AW(AW), .LW(LW), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .oclk_held(oclk_held),
    .rd_n(rd_n), .rd_addr(rd_addr), .wr_n(wr_n), .wr_addr(wr_addr),
    .wdata(wdata), .bwe_n(bwe_n), .kphase(kphase), .q(q), .q_oe(q_oe)
  );

  int total = 0, bad = 0, ecnt = 0, lat = 2;
  bit chk_on = 1'b0, done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_q [NB];
  bit            exp_v [NB];
  int            exp_r [NB];

  // rdn ra wrn wa d0 b0 d1 b1  (58 bits)
  localparam int NV = 12;
  localparam logic [57:0] VEC [NV] = '{
    {1'b0, 8'h10, 1'b0, 8'h40, 18'h1_2345, 2'b00, 18'h2_3456, 2'b00},
    {1'b0, 8'h40, 1'b1, 8'h00, 18'h0_0000, 2'b11, 18'h0_0000, 2'b11},
    {1'b1, 8'h00, 1'b0, 8'h41, 18'h3_0F0F, 2'b00, 18'h0_F0F0, 2'b00},
    {1'b0, 8'h41, 1'b0, 8'h80, 18'h1_1111, 2'b10, 18'h2_2222, 2'b01},
    {1'b0, 8'h80, 1'b1, 8'h00, 18'h0_0000, 2'b11, 18'h0_0000, 2'b11},
    {1'b0, 8'h7F, 1'b0, 8'h7F, 18'h3_AAAA, 2'b00, 18'h1_5555, 2'b00},
    {1'b0, 8'h7F, 1'b1, 8'h00, 18'h0_0000, 2'b11, 18'h0_0000, 2'b11},
    {1'b1, 8'h00, 1'b1, 8'h00, 18'h0_0000, 2'b11, 18'h0_0000, 2'b11},
    {1'b0, 8'h03, 1'b0, 8'h05, 18'h0_0001, 2'b00, 18'h0_0002, 2'b00},
    {1'b0, 8'h04, 1'b0, 8'h06, 18'h0_0003, 2'b11, 18'h0_0004, 2'b00},
    {1'b0, 8'h05, 1'b1, 8'h00, 18'h0_0000, 2'b11, 18'h0_0000, 2'b11},
    {1'b0, 8'h06, 1'b1, 8'h00, 18'h0_0000, 2'b11, 18'h0_0000, 2'b11}
  };

  always @(posedge clk) ecnt <= ecnt + 1;

  // Per-beat read-bus check (R4 R5 R6 R7 R9 via exp_r)
  always @(negedge clk) begin
    if (chk_on && !done && ecnt < NB) begin
      total++;
      if (exp_v[ecnt]) begin
        if (q_oe !== 1'b1 || q !== exp_q[ecnt]) begin
          bad++;
          $display("FAIL R%0d beat %0d: oe=%b q=%h expected oe=1 q=%h",
                   exp_r[ecnt], ecnt, q_oe, q, exp_q[ecnt]);
        end
      end else if (q_oe !== 1'b0 || q !== '0) begin
        bad++;
        $display("FAIL R6 beat %0d: oe=%b q=%h expected oe=0 q=0", ecnt, q_oe, q);
      end
    end
  end

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [LANES-1:0] ben);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (!ben[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 1237) ^ 18'h2_5A5A);
  endfunction

  task automatic chk1(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exv);
    end
  endtask

  // One K cycle; K-fall beat deliberately drives low selects (R2: ignored)
  task automatic kcyc(bit rdn, logic [AW-1:0] ra, bit wrn, logic [AW-1:0] wa,
                      logic [DW-1:0] d0, logic [LANES-1:0] b0,
                      logic [DW-1:0] d1, logic [LANES-1:0] b1, int rq);
    logic [AW-1:0] ra1 = ra + 1'b1;
    logic [AW-1:0] wa1 = wa + 1'b1;
    while (kphase !== 1'b1) @(negedge clk);
    rd_n = rdn; rd_addr = ra; wr_n = wrn; wr_addr = wa; wdata = d0; bwe_n = b0;
    if (!rdn) begin
      exp_q[ecnt+lat+1] = ref_mem[ra];  exp_v[ecnt+lat+1] = 1'b1; exp_r[ecnt+lat+1] = rq;
      exp_q[ecnt+lat+2] = ref_mem[ra1]; exp_v[ecnt+lat+2] = 1'b1; exp_r[ecnt+lat+2] = rq;
    end
    if (!wrn) begin
      ref_mem[wa]  = merge(ref_mem[wa], d0, b0);
      ref_mem[wa1] = merge(ref_mem[wa1], d1, b1);
    end
    @(negedge clk);
    rd_n = 1'b0; wr_n = 1'b0; rd_addr = ~ra; wr_addr = ~wa; wdata = d1; bwe_n = b1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit held);
    chk_on = 1'b0;
    rst = 1'b1; oclk_held = held; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs held in reset state
    chk1(kphase === 1'b1, "R10", "kphase in reset", DW'(kphase), DW'(1));
    chk1(q_oe === 1'b0, "R10", "q_oe in reset", DW'(q_oe), '0);
    chk1(q === '0, "R10", "q in reset", q, '0);
    rst = 1'b0;
    lat = held ? 2 : 3;
    @(negedge clk);
    // R2: phase toggled on the first edge after reset
    chk1(kphase === 1'b0, "R2", "kphase after first edge", DW'(kphase), '0);
    chk_on = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog: cycles=150000 expected completion earlier");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rd_addr = '0; wr_addr = '0; wdata = '0; bwe_n = '1; rst = 1'b1; oclk_held = 1'b1;
    do_reset(1'b1);

    // R1: fill every address with bursts of two
    for (int i = 0; i < DEPTH / 2; i++)
      kcyc(1'b1, '0, 1'b0, AW'(2*i), pat(2*i), '0, pat(2*i+1), '0, 1);
    // R7: back-to-back reads over the whole array, R4 latency
    for (int i = 0; i < DEPTH / 2; i++)
      kcyc(1'b0, AW'(2*i), 1'b1, '0, '0, '1, '0, '1, 7);
    idle(6);

    // Vector table: mixed concurrent traffic (R3, R8)
    for (int v = 0; v < NV; v++)
      kcyc(VEC[v][57], VEC[v][56:49], VEC[v][48], VEC[v][47:40],
           VEC[v][39:22], VEC[v][21:20], VEC[v][19:2], VEC[v][1:0], 3);
    idle(6);

    // R3: same base on both ports, then read again
    kcyc(1'b0, 8'h22, 1'b0, 8'h22, 18'h3_1234, '0, 18'h0_4321, '0, 3);
    kcyc(1'b0, 8'h22, 1'b1, '0, '0, '1, '0, '1, 3);
    idle(6);

    // R1: wrap from the top address to zero
    kcyc(1'b1, '0, 1'b0, 8'hFF, 18'h1_FFFF, '0, 18'h2_0001, '0, 1);
    kcyc(1'b0, 8'hFF, 1'b1, '0, '0, '1, '0, '1, 1);
    idle(6);

    // R8: lane 0 masked on word 0, lane 1 masked on word 1
    kcyc(1'b1, '0, 1'b0, 8'h30, 18'h3_FFFF, 2'b01, 18'h3_FFFF, 2'b10, 8);
    kcyc(1'b0, 8'h30, 1'b1, '0, '0, '1, '0, '1, 8);
    idle(6);

    // R9: single read, select released; bus idles after two words
    kcyc(1'b0, 8'h55, 1'b1, '0, '0, '1, '0, '1, 9);
    idle(8);

    // R5, R10: split output timing after reset, memory retained
    do_reset(1'b0);
    kcyc(1'b0, 8'h30, 1'b1, '0, '0, '1, '0, '1, 5);
    kcyc(1'b0, 8'hFF, 1'b0, 8'h31, 18'h0_1357, '0, 18'h0_2468, '0, 5);
    kcyc(1'b0, 8'h31, 1'b1, '0, '0, '1, '0, '1, 5);
    idle(8);
    kcyc(1'b0, 8'h22, 1'b1, '0, '0, '1, '0, '1, 10);
    idle(8);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule